// File: doc/BRIEF.md
# I/Q Sample Offset Adder

This block adds a small programmable signed correction to each of two converter sample streams, an in-phase (I) stream and a quadrature (Q) stream. Each sum is clamped to the sample range and registered, so every output is one clock cycle behind its input. Software programs the corrections through a plain register write port, which has an address, a data byte and a write enable.

The corrections are written indirectly. A first write to a channel-select register picks the I or the Q channel. A write to a shared offset register then places a value into that channel's staged (shadow) register. The datapath keeps using the previous active values until a write to an update register copies both staged values into the active registers in one step. Both channels therefore change their correction on the same clock edge.

Top module: `iq_offset_adder`

## Requirements
- R1: While `rst` is high, both outputs are 0. After reset, the channel select is 0x00, and all staged and active offsets are 0, so each output equals its input.
- R2: Each output is registered. The output in cycle n+1 equals the input sampled in cycle n plus that channel's active offset as it stood in cycle n.
- R3: A write to address 0x05 sets the channel select. The value 0x01 selects I and 0x02 selects Q. A write to address 0x10 stores into the staged offset of the selected channel.
- R4: Staged offsets do not reach the datapath on their own. A write to address 0xFF with data bit 0 set copies both staged offsets into the active offsets on that clock edge. A write to 0xFF with bit 0 clear changes nothing.
- R5: A write to 0x10 is ignored when the channel select holds 0x00 or any value other than 0x01 or 0x02.
- R6: Only bits [5:0] of an offset write are kept. They are read as a 6-bit two's complement value and sign-extended, so 0xFE gives -2, 0xE0 gives -32, 0x1F gives +31 and 0x7F gives -1.
- R7: Samples are 12-bit two's complement. A sum above 2047 gives 2047, and a sum below -2048 gives -2048. Sums never wrap.
- R8: The I and Q channels hold separate offsets. Writing or committing a value for one channel leaves the other channel's output unchanged.
- R9: An update acts once. A staged write made after an update stays inactive until the next update write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| i_in | input | 12 | I sample, two's complement |
| q_in | input | 12 | Q sample, two's complement |
| i_out | output | 12 | I sample plus active offset, saturated |
| q_out | output | 12 | Q sample plus active offset, saturated |

## Verification
The hardest case to reach is a staged offset that differs from the active offset while samples keep flowing. In that state the output must still follow the old value. The stimulus produces it by writing new staged values, and by sending update writes with bit 0 clear, and checks the outputs before each real commit. It also commits a new value in the middle of a run to show that the change happens exactly once. Ignored offset writes are made under a select of 0x00 and under an unlisted select value. A later commit then shows that neither staged register was touched.

// File: rtl/iqofs_pkg.sv
package iqofs_pkg;
  localparam int NCH  = 2;
  localparam int CH_I = 0;
  localparam int CH_Q = 1;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_SEL,
    OP_OFS,
    OP_UPD
  } wr_op_e;
endpackage

// File: rtl/iqofs_regs.sv
module iqofs_regs
  import iqofs_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter int          OFS_W    = 6,
  parameter int          CH_N     = NCH,
  parameter logic [7:0]  SEL_ADDR = 8'h05,
  parameter logic [7:0]  OFS_ADDR = 8'h10,
  parameter logic [7:0]  UPD_ADDR = 8'hFF
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            sel_o,
  output logic [CH_N-1:0][OFS_W-1:0]   shadow_o,
  output logic [CH_N-1:0][OFS_W-1:0]   active_o
);
  wr_op_e op;

  always_comb begin
    op = OP_NONE;
    if (wr_en) begin
      if (wr_addr == ADDR_W'(SEL_ADDR))      op = OP_SEL;
      else if (wr_addr == ADDR_W'(OFS_ADDR)) op = OP_OFS;
      else if (wr_addr == ADDR_W'(UPD_ADDR)) op = OP_UPD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                sel_o <= '0;
    else if (op == OP_SEL)  sel_o <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_o <= '0;
      active_o <= '0;
    end else begin
      for (int ch = 0; ch < CH_N; ch++) begin
        if (op == OP_OFS && sel_o == DATA_W'(ch + 1))
          shadow_o[ch] <= wr_data[OFS_W-1:0];
      end
      if (op == OP_UPD && wr_data[0])
        active_o <= shadow_o;
    end
  end
endmodule

// File: rtl/iqofs_sat_add.sv
module iqofs_sat_add #(
  parameter int SAMPLE_W = 12,
  parameter int OFS_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] samp_i,
  input  logic [OFS_W-1:0]    ofs_i,
  output logic [SAMPLE_W-1:0] sum_o
);
  localparam int SUM_W = SAMPLE_W + 1;
  localparam logic [SAMPLE_W-1:0] POS_LIM = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] NEG_LIM = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SUM_W-1:0]    wide;
  logic [SAMPLE_W-1:0] clamped;

  assign wide = {samp_i[SAMPLE_W-1], samp_i}
              + {{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};

  always_comb begin
    if (wide[SUM_W-1] != wide[SUM_W-2])
      clamped = wide[SUM_W-1] ? NEG_LIM : POS_LIM;
    else
      clamped = wide[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) sum_o <= '0;
    else     sum_o <= clamped;
  end
endmodule

// File: rtl/iq_offset_adder.sv
module iq_offset_adder
  import iqofs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int OFS_W    = 6,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [SAMPLE_W-1:0] i_in,
  input  logic [SAMPLE_W-1:0] q_in,
  output logic [SAMPLE_W-1:0] i_out,
  output logic [SAMPLE_W-1:0] q_out
);
  logic [DATA_W-1:0]           sel_q;
  logic [NCH-1:0][OFS_W-1:0]   shadow_ofs;
  logic [NCH-1:0][OFS_W-1:0]   active_ofs;
  logic [NCH-1:0][SAMPLE_W-1:0] samp_in;
  logic [NCH-1:0][SAMPLE_W-1:0] samp_out;

  assign samp_in[CH_I] = i_in;
  assign samp_in[CH_Q] = q_in;
  assign i_out = samp_out[CH_I];
  assign q_out = samp_out[CH_Q];

  iqofs_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .CH_N(NCH)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_o(sel_q), .shadow_o(shadow_ofs), .active_o(active_ofs)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    iqofs_sat_add #(.SAMPLE_W(SAMPLE_W), .OFS_W(OFS_W)) u_add (
      .clk(clk), .rst(rst), .samp_i(samp_in[ch]), .ofs_i(active_ofs[ch]),
      .sum_o(samp_out[ch])
    );
  end
endmodule

// File: rtl/iq_offset_adder_chk.sv
module iq_offset_adder_chk #(
  parameter int SAMPLE_W = 12,
  parameter int OFS_W    = 6,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [DATA_W-1:0]     wr_data,
  input logic [SAMPLE_W-1:0]   i_in,
  input logic [SAMPLE_W-1:0]   i_out,
  input logic [DATA_W-1:0]     sel,
  input logic [1:0][OFS_W-1:0] shd,
  input logic [1:0][OFS_W-1:0] act
);
  localparam logic [SAMPLE_W-1:0] POS_LIM = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] NEG_LIM = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic upd_wr, ofs_wr;
  assign upd_wr = wr_en && wr_addr == ADDR_W'(8'hFF) && wr_data[0];
  assign ofs_wr = wr_en && wr_addr == ADDR_W'(8'h10);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sel == '0 && shd == '0 && act == '0 && i_out == '0));

  // R4
  hold_active_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_wr |=> $stable(act));

  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    upd_wr |=> act == $past(shd));

  // R5
  ignore_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ofs_wr && sel != DATA_W'(1) && sel != DATA_W'(2)) |=> $stable(shd));

  // R3
  stage_i_chk: assert property (@(posedge clk) disable iff (rst)
    (ofs_wr && sel == DATA_W'(1)) |=>
      (shd[0] == $past(wr_data[OFS_W-1:0]) && $stable(shd[1])));

  // R7
  clamp_high_chk: assert property (@(posedge clk) disable iff (rst)
    (i_in == POS_LIM && !act[0][OFS_W-1]) |=> i_out == POS_LIM);

  // R7
  clamp_low_chk: assert property (@(posedge clk) disable iff (rst)
    (i_in == NEG_LIM && act[0][OFS_W-1]) |=> i_out == NEG_LIM);
endmodule

bind iq_offset_adder iq_offset_adder_chk #(
  .SAMPLE_W(SAMPLE_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .i_in(i_in), .i_out(i_out), .sel(sel_q), .shd(shadow_ofs), .act(active_ofs)
);

// File: tb/iq_offset_adder_test.sv
module iq_offset_adder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [11:0] i_in = '0;
  logic [11:0] q_in = '0;
  logic [11:0] i_out, q_out;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  iq_offset_adder uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .i_in(i_in), .q_in(q_in), .i_out(i_out), .q_out(q_out)
  );

  // Columns: i in, q in, expected i, expected q (offsets I=+6, Q=-2)
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{    0,     0,     6,    -2},
    '{  100,  -100,   106,  -102},
    '{ 2047,  2047,  2047,  2045},
    '{ 2044, -2048,  2047, -2048},
    '{-2048, -2047, -2042, -2048},
    '{ 2041,     1,  2047,    -1},
    '{   -6,     2,     0,     0},
    '{-1000,   500,  -994,   498}
  };

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic samp(input int i, input int q, input int ei, input int eq,
                      input string req);
    @(negedge clk);
    i_in = 12'(i); q_in = 12'(q);
    @(negedge clk);
    check({req, " i"}, int'($signed(i_out)), ei);
    check({req, " q"}, int'($signed(q_out)), eq);
  endtask

  initial begin
    i_in = 12'd5; q_in = 12'd7;
    repeat (3) @(negedge clk);
    check("R1 i during reset", int'($signed(i_out)), 0);
    check("R1 q during reset", int'($signed(q_out)), 0);
    rst = 1'b0;
    samp(123, -45, 123, -45, "R1 no offset after reset");

    wr(8'h05, 8'h01); wr(8'h10, 8'h06);
    samp(10, 10, 10, 10, "R4 staged not applied");
    wr(8'hFF, 8'h00);
    samp(10, 10, 10, 10, "R4 update bit clear");
    wr(8'h05, 8'h02); wr(8'h10, 8'hFE); wr(8'hFF, 8'h01);
    samp(10, 10, 16, 8, "R3 committed I=+6 Q=-2");

    // R2 R7 R8 vector walk
    for (int k = 0; k < NV; k++)
      samp(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], "R2 R7 vector");

    wr(8'h05, 8'h00); wr(8'h10, 8'h1F);
    wr(8'h05, 8'h03); wr(8'h10, 8'h1F);
    wr(8'hFF, 8'h01);
    samp(0, 0, 6, -2, "R5 write ignored");

    wr(8'h05, 8'h01); wr(8'h10, 8'hE0); wr(8'hFF, 8'h01);
    samp(0, 0, -32, -2, "R6 R8 0xE0 is -32");
    wr(8'h10, 8'h1F);
    samp(0, 0, -32, -2, "R9 staged waits");
    wr(8'hFF, 8'h01);
    samp(0, 0, 31, -2, "R6 0x1F is +31");
    wr(8'h10, 8'h7F); wr(8'hFF, 8'h01);
    samp(100, 0, 99, -2, "R6 upper bits dropped");

    wr(8'h05, 8'h02); wr(8'h10, 8'h20); wr(8'hFF, 8'h01);
    samp(-2040, -2040, -2041, -2048, "R7 R8 Q clamps low");
    wr(8'h05, 8'h00);
    samp(5, 5, 4, -27, "R8 final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule